// File: doc/BRIEF.md
# PC Card Flash Array Interface Controller

This block sits between a 16-bit memory-style PC Card host bus and an array of byte-wide flash devices fitted in pairs, one device per byte lane. From the two active-low card enables, the byte address bit, the attribute-plane select and the output and write enables, it derives one chip select per device pair and four lane strobes: read and write for the low device and for the high device. It steers the host data lanes to and from the two flash bytes, so that an 8-bit host can reach every byte on the low lane. It also routes attribute-plane accesses to a small external memory port, applies a hardware write-protect input, and merges the per-device busy outputs into one ready/busy line.

The host side is a strobe bus, not a stream. Data is valid while the strobes are held, and no wait states are ever inserted. For that reason no valid/ready handshake is used, and the block applies no back-pressure. Decode and steering are combinational from the host pins. Only the busy merge is clocked: it passes through a synchronizer of `SYNC_STAGES` flops.

Top module: `pcf_array_ctrl`

## Requirements
- R1: With both card enables low, a word access occurs. The low device maps to bits 7:0 and the high device maps to bits 15:8, both lanes are driven on a read, and `addr[0]` has no effect.
- R2: With only `ce_even_n` low, `addr[0]`=0 selects the low device and `addr[0]`=1 selects the high device. Either way the byte travels on host bits 7:0 for both read and write, and only that device's strobe is asserted.
- R3: With only `ce_odd_n` low, the high device is accessed on host bits 15:8. Only read-drive bit 1 and the high strobes are active.
- R4: With both card enables high, no chip select and no strobe is asserted, and `host_rdata_oe` is 2'b00.
- R5: In common memory (`reg_sel_n`=1), `addr[25:23]` selects the pair whose `pair_cs_n` bit goes low. At most one bit is low at a time. `flash_addr` equals `addr[22:1]`.
- R6: A read strobe is asserted when `oe_n`=0 and `we_n`=1. A write strobe is asserted when `we_n`=0 and `oe_n`=1. With both low, neither strobe is asserted.
- R7: With `reg_sel_n`=0, no pair chip select and no flash strobe is asserted. `attr_cs` is asserted only when the low lane is addressed (even byte), and `attr_addr` equals `addr[11:1]`. A read of an odd attribute byte returns 8'hFF.
- R8: With `wp`=1, both flash write strobes stay high. Attribute writes (`attr_we`) are not affected.
- R9: `rdy_bsy` goes low `SYNC_STAGES` clock edges after any `dev_busy` bit goes high. It returns high the same number of edges after all bits are clear.
- R10: While `rst`=1, all chip selects and strobes are high, `host_rdata_oe` is 0 and `rdy_bsy` is 1.
- R11: `wait_n`, `bvd1` and `bvd2` are always 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the busy synchronizer |
| rst | input | 1 | Card reset, active high |
| ce_even_n | input | 1 | Even-byte card enable, active low |
| ce_odd_n | input | 1 | Odd-byte card enable, active low |
| reg_sel_n | input | 1 | Attribute-plane select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| wp | input | 1 | Write protect, 1 = locked |
| addr | input | 26 | Host byte address |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data |
| host_rdata_oe | output | 2 | Read drive enable per host lane (bit0 = 7:0) |
| rdy_bsy | output | 1 | 1 = all devices ready |
| wait_n | output | 1 | Constant 1 |
| bvd1 | output | 1 | Constant 1 |
| bvd2 | output | 1 | Constant 1 |
| pair_cs_n | output | 8 | Device-pair chip selects, active low |
| flash_addr | output | 22 | In-pair word address |
| rl_n | output | 1 | Low device read strobe |
| wl_n | output | 1 | Low device write strobe |
| rh_n | output | 1 | High device read strobe |
| wh_n | output | 1 | High device write strobe |
| flash_lo_wdata | output | 8 | Write data to low device |
| flash_hi_wdata | output | 8 | Write data to high device |
| flash_lo_rdata | input | 8 | Read data from low device |
| flash_hi_rdata | input | 8 | Read data from high device |
| dev_busy | input | 16 | Busy flag per device |
| attr_cs | output | 1 | Attribute memory select |
| attr_we | output | 1 | Attribute memory write |
| attr_addr | output | 11 | Attribute byte-pair address |
| attr_wdata | output | 8 | Attribute write data |
| attr_rdata | input | 8 | Attribute read data |

## Verification
The hardest case to reach is the 8-bit host reaching the odd device. That needs `ce_odd_n` high, `ce_even_n` low and `addr[0]` set. The bench must then show that the high device's data arrives on host bits 7:0, that only the high strobes fire, and that a write carries the low host byte into the high device. The bench drives this directly with distinct byte values on each device. It then repeats the access under write protect and on the attribute plane, where the odd byte must read back as 8'hFF. The synchronizer edge count is checked by sampling `rdy_bsy` one edge before and one edge at the expected change.

// File: rtl/pcf_pkg.sv
package pcf_pkg;
  // Which flash byte lanes an access touches and how host lane 0 is sourced
  typedef struct packed {
    logic lo;     // low (even) device addressed
    logic hi;     // high (odd) device addressed
    logic swap;   // high device byte carried on host bits 7:0
    logic drv0;   // host bits 7:0 take part
    logic drv1;   // host bits 15:8 take part
  } pcf_lanes_t;

  localparam logic [7:0] PCF_ODD_ATTR_FILL = 8'hFF;
endpackage

// File: rtl/pcf_lane_decode.sv
module pcf_lane_decode
  import pcf_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       ce_even_n,
  input  logic       ce_odd_n,
  input  logic       a0,
  input  logic       reg_sel_n,
  input  logic       oe_n,
  input  logic       we_n,
  input  logic       wp,
  output pcf_lanes_t lanes,
  output logic       common_en,
  output logic       attr_en,
  output logic       rd,
  output logic       rl_n,
  output logic       wl_n,
  output logic       rh_n,
  output logic       wh_n,
  output logic       attr_cs,
  output logic       attr_we
);
  logic any_ce, word, even_only, odd_only, wr, wr_flash;

  always_comb begin
    any_ce    = !ce_even_n || !ce_odd_n;
    word      = !ce_even_n && !ce_odd_n;
    even_only = !ce_even_n && ce_odd_n;
    odd_only  = ce_even_n && !ce_odd_n;

    lanes.lo   = word || (even_only && !a0);
    lanes.hi   = word || (even_only && a0) || odd_only;
    lanes.swap = even_only && a0;
    lanes.drv0 = !ce_even_n;
    lanes.drv1 = !ce_odd_n;

    common_en = !rst && any_ce && reg_sel_n;
    attr_en   = !rst && any_ce && !reg_sel_n;
    rd        = !oe_n && we_n;
    wr        = !we_n && oe_n;
    wr_flash  = wr && !wp;

    rl_n    = !(common_en && lanes.lo && rd);
    rh_n    = !(common_en && lanes.hi && rd);
    wl_n    = !(common_en && lanes.lo && wr_flash);
    wh_n    = !(common_en && lanes.hi && wr_flash);
    attr_cs = attr_en && lanes.lo;
    attr_we = attr_cs && wr;
  end

  p_wp_lock_r8: assert property (@(posedge clk) disable iff (rst)
    wp |-> (wl_n && wh_n));
  p_rd_wr_excl_r6: assert property (@(posedge clk) disable iff (rst)
    (!oe_n && !we_n) |-> (rl_n && rh_n && wl_n && wh_n && !attr_we));
  p_idle_r4: assert property (@(posedge clk) disable iff (rst)
    (ce_even_n && ce_odd_n) |-> (rl_n && rh_n && wl_n && wh_n && !attr_cs));
  p_attr_no_flash_r7: assert property (@(posedge clk) disable iff (rst)
    !reg_sel_n |-> (rl_n && rh_n && wl_n && wh_n));
endmodule

// File: rtl/pcf_data_steer.sv
module pcf_data_steer
  import pcf_pkg::*;
(
  input  pcf_lanes_t  lanes,
  input  logic        common_en,
  input  logic        attr_en,
  input  logic        rd,
  input  logic [15:0] host_wdata,
  input  logic [7:0]  flash_lo_rdata,
  input  logic [7:0]  flash_hi_rdata,
  input  logic [7:0]  attr_rdata,
  output logic [15:0] host_rdata,
  output logic [1:0]  host_rdata_oe,
  output logic [7:0]  flash_lo_wdata,
  output logic [7:0]  flash_hi_wdata,
  output logic [7:0]  attr_wdata
);
  logic [7:0] lo_src, hi_src;
  logic       reading;

  always_comb begin
    lo_src  = common_en ? flash_lo_rdata : attr_rdata;
    hi_src  = common_en ? flash_hi_rdata : PCF_ODD_ATTR_FILL;
    reading = rd && (common_en || attr_en);

    host_rdata[7:0]  = lanes.swap ? hi_src : lo_src;
    host_rdata[15:8] = hi_src;
    host_rdata_oe    = {reading && lanes.drv1, reading && lanes.drv0};

    flash_lo_wdata = host_wdata[7:0];
    flash_hi_wdata = lanes.swap ? host_wdata[7:0] : host_wdata[15:8];
    attr_wdata     = host_wdata[7:0];
  end
endmodule

// File: rtl/pcf_busy_sync.sv
module pcf_busy_sync #(
  parameter int NDEV        = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NDEV-1:0] dev_busy,
  output logic            rdy_bsy
);
  logic [SYNC_STAGES-1:0] sync_q;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '0;
    else     sync_q <= {sync_q[SYNC_STAGES-2:0], |dev_busy};
  end

  assign rdy_bsy = !sync_q[SYNC_STAGES-1];

  p_ready_after_reset_r10: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> rdy_bsy);
  p_idle_stays_ready_r9: assert property (@(posedge clk) disable iff (rst)
    (rdy_bsy && !(|sync_q)) |=> (rdy_bsy));
endmodule

// File: rtl/pcf_array_ctrl.sv
module pcf_array_ctrl
  import pcf_pkg::*;
#(
  parameter int NPAIRS         = 8,
  parameter int DEV_WORD_BITS  = 22,
  parameter int ATTR_ADDR_BITS = 11,
  parameter int SYNC_STAGES    = 2,
  localparam int PAIR_BITS     = $clog2(NPAIRS),
  localparam int ADDR_W        = 1 + DEV_WORD_BITS + PAIR_BITS,
  localparam int NDEV          = 2 * NPAIRS
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      ce_even_n,
  input  logic                      ce_odd_n,
  input  logic                      reg_sel_n,
  input  logic                      oe_n,
  input  logic                      we_n,
  input  logic                      wp,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [15:0]               host_wdata,
  output logic [15:0]               host_rdata,
  output logic [1:0]                host_rdata_oe,
  output logic                      rdy_bsy,
  output logic                      wait_n,
  output logic                      bvd1,
  output logic                      bvd2,
  output logic [NPAIRS-1:0]         pair_cs_n,
  output logic [DEV_WORD_BITS-1:0]  flash_addr,
  output logic                      rl_n,
  output logic                      wl_n,
  output logic                      rh_n,
  output logic                      wh_n,
  output logic [7:0]                flash_lo_wdata,
  output logic [7:0]                flash_hi_wdata,
  input  logic [7:0]                flash_lo_rdata,
  input  logic [7:0]                flash_hi_rdata,
  input  logic [NDEV-1:0]           dev_busy,
  output logic                      attr_cs,
  output logic                      attr_we,
  output logic [ATTR_ADDR_BITS-1:0] attr_addr,
  output logic [7:0]                attr_wdata,
  input  logic [7:0]                attr_rdata
);
  pcf_lanes_t           lanes;
  logic                 common_en, attr_en, rd;
  logic [PAIR_BITS-1:0] pair_idx;

  assign wait_n = 1'b1;
  assign bvd1   = 1'b1;
  assign bvd2   = 1'b1;

  assign pair_idx   = addr[ADDR_W-1 -: PAIR_BITS];
  assign flash_addr = addr[DEV_WORD_BITS:1];
  assign attr_addr  = addr[ATTR_ADDR_BITS:1];

  for (genvar p = 0; p < NPAIRS; p++) begin : g_pair_cs
    assign pair_cs_n[p] = !(common_en && (pair_idx == PAIR_BITS'(p)));
  end

  pcf_lane_decode u_decode (
    .clk(clk), .rst(rst), .ce_even_n(ce_even_n), .ce_odd_n(ce_odd_n),
    .a0(addr[0]), .reg_sel_n(reg_sel_n), .oe_n(oe_n), .we_n(we_n), .wp(wp),
    .lanes(lanes), .common_en(common_en), .attr_en(attr_en), .rd(rd),
    .rl_n(rl_n), .wl_n(wl_n), .rh_n(rh_n), .wh_n(wh_n),
    .attr_cs(attr_cs), .attr_we(attr_we)
  );

  pcf_data_steer u_steer (
    .lanes(lanes), .common_en(common_en), .attr_en(attr_en), .rd(rd),
    .host_wdata(host_wdata), .flash_lo_rdata(flash_lo_rdata),
    .flash_hi_rdata(flash_hi_rdata), .attr_rdata(attr_rdata),
    .host_rdata(host_rdata), .host_rdata_oe(host_rdata_oe),
    .flash_lo_wdata(flash_lo_wdata), .flash_hi_wdata(flash_hi_wdata),
    .attr_wdata(attr_wdata)
  );

  pcf_busy_sync #(.NDEV(NDEV), .SYNC_STAGES(SYNC_STAGES)) u_busy (
    .clk(clk), .rst(rst), .dev_busy(dev_busy), .rdy_bsy(rdy_bsy)
  );

  p_one_pair_r5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~pair_cs_n));
  p_attr_no_cs_r7: assert property (@(posedge clk) disable iff (rst)
    !reg_sel_n |-> (&pair_cs_n));
  p_strobe_needs_cs_r5: assert property (@(posedge clk) disable iff (rst)
    (!rl_n || !rh_n || !wl_n || !wh_n) |-> !(&pair_cs_n));
  p_static_pins_r11: assert property (@(posedge clk) disable iff (rst)
    wait_n && bvd1 && bvd2);
endmodule

// File: tb/pcf_array_ctrl_tb.sv
module pcf_array_ctrl_tb;
  logic        clk = 0, rst = 1;
  logic        ce_even_n = 1, ce_odd_n = 1, reg_sel_n = 1, oe_n = 1, we_n = 1, wp = 0;
  logic [25:0] addr = '0;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata;
  logic [1:0]  host_rdata_oe;
  logic        rdy_bsy, wait_n, bvd1, bvd2;
  logic [7:0]  pair_cs_n;
  logic [21:0] flash_addr;
  logic        rl_n, wl_n, rh_n, wh_n;
  logic [7:0]  flash_lo_wdata, flash_hi_wdata;
  logic [7:0]  flash_lo_rdata = 8'hA5, flash_hi_rdata = 8'h3C;
  logic [15:0] dev_busy = '0;
  logic        attr_cs, attr_we;
  logic [10:0] attr_addr;
  logic [7:0]  attr_wdata;
  logic [7:0]  attr_rdata = 8'h5A;

  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  pcf_array_ctrl u_dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // strobes packed {rl_n, wl_n, rh_n, wh_n}
  function automatic logic [3:0] strb();
    return {rl_n, wl_n, rh_n, wh_n};
  endfunction

  task automatic set_bus(input logic e, input logic o, input logic r,
                         input logic oe, input logic we, input logic [25:0] a);
    @(negedge clk);
    ce_even_n = e; ce_odd_n = o; reg_sel_n = r; oe_n = oe; we_n = we; addr = a;
    #1;
  endtask

  task automatic t_reset();
    rst = 1;
    set_bus(0, 0, 1, 0, 1, 26'h0);
    chk("R10 cs", {24'h0, pair_cs_n}, 32'hFF);
    chk("R10 strobes", {28'h0, strb()}, 32'hF);
    chk("R10 oe", {30'h0, host_rdata_oe}, 32'h0);
    chk("R10 rdy", {31'h0, rdy_bsy}, 32'h1);
    @(negedge clk); rst = 0;
  endtask

  task automatic t_idle();
    set_bus(1, 1, 1, 0, 1, 26'h1234567);
    chk("R4 cs", {24'h0, pair_cs_n}, 32'hFF);
    chk("R4 strobes", {28'h0, strb()}, 32'hF);
    chk("R4 oe", {30'h0, host_rdata_oe}, 32'h0);
    chk("R11 pins", {29'h0, wait_n, bvd1, bvd2}, 32'h7);
  endtask

  task automatic t_word();
    for (int a0 = 0; a0 < 2; a0++) begin
      set_bus(0, 0, 1, 0, 1, {3'd5, 22'h2ABCDE, 1'(a0)});
      chk("R1 rdata", {16'h0, host_rdata}, 32'h3CA5);
      chk("R1 oe", {30'h0, host_rdata_oe}, 32'h3);
      chk("R1 strobes", {28'h0, strb()}, 32'b0101);
      chk("R5 cs", {24'h0, pair_cs_n}, 32'hDF);
      chk("R5 flash_addr", {10'h0, flash_addr}, 32'h2ABCDE);
    end
    host_wdata = 16'hBEEF;
    set_bus(0, 0, 1, 1, 0, {3'd0, 22'h1, 1'b1});
    chk("R1 wr strobes", {28'h0, strb()}, 32'b1010);
    chk("R1 wr data", {16'h0, flash_hi_wdata, flash_lo_wdata}, 32'hBEEF);
    chk("R5 cs pair0", {24'h0, pair_cs_n}, 32'hFE);
  endtask

  task automatic t_even_only();
    set_bus(0, 1, 1, 0, 1, {3'd7, 22'h0, 1'b0});
    chk("R2 even rd", {24'h0, host_rdata[7:0]}, 32'hA5);
    chk("R2 even oe", {30'h0, host_rdata_oe}, 32'h1);
    chk("R2 even strb", {28'h0, strb()}, 32'b0111);
    chk("R5 cs pair7", {24'h0, pair_cs_n}, 32'h7F);
    set_bus(0, 1, 1, 0, 1, {3'd7, 22'h0, 1'b1});
    chk("R2 odd-on-lane0 rd", {24'h0, host_rdata[7:0]}, 32'h3C);
    chk("R2 odd strb", {28'h0, strb()}, 32'b1101);
    host_wdata = 16'h1177;
    set_bus(0, 1, 1, 1, 0, {3'd2, 22'h0, 1'b1});
    chk("R2 odd wr strb", {28'h0, strb()}, 32'b1110);
    chk("R2 odd wr data", {24'h0, flash_hi_wdata}, 32'h77);
  endtask

  task automatic t_odd_only();
    set_bus(1, 0, 1, 0, 1, {3'd3, 22'h5, 1'b1});
    chk("R3 rdata hi", {24'h0, host_rdata[15:8]}, 32'h3C);
    chk("R3 oe", {30'h0, host_rdata_oe}, 32'h2);
    chk("R3 strb", {28'h0, strb()}, 32'b1101);
  endtask

  task automatic t_rw_both();
    set_bus(0, 0, 1, 0, 0, 26'h0);
    chk("R6 both low strb", {28'h0, strb()}, 32'hF);
    chk("R6 both low oe", {30'h0, host_rdata_oe}, 32'h0);
  endtask

  task automatic t_attr();
    set_bus(0, 0, 0, 0, 1, {14'h0, 11'h2A5, 1'b0});
    chk("R7 cs", {24'h0, pair_cs_n}, 32'hFF);
    chk("R7 strb", {28'h0, strb()}, 32'hF);
    chk("R7 attr_cs", {31'h0, attr_cs}, 32'h1);
    chk("R7 attr_addr", {21'h0, attr_addr}, 32'h2A5);
    chk("R7 rdata", {16'h0, host_rdata}, 32'hFF5A);
    set_bus(0, 1, 0, 0, 1, {14'h0, 11'h3, 1'b1});
    chk("R7 odd attr_cs", {31'h0, attr_cs}, 32'h0);
    chk("R7 odd rdata", {24'h0, host_rdata[7:0]}, 32'hFF);
  endtask

  task automatic t_wp();
    wp = 1;
    set_bus(0, 0, 1, 1, 0, 26'h0);
    chk("R8 flash wr locked", {28'h0, strb()}, 32'hF);
    set_bus(0, 1, 0, 1, 0, 26'h0);
    chk("R8 attr wr allowed", {31'h0, attr_we}, 32'h1);
    wp = 0;
    set_bus(0, 1, 1, 1, 0, 26'h0);
    chk("R8 wp off", {31'h0, wl_n}, 32'h0);
  endtask

  task automatic t_busy();
    set_bus(1, 1, 1, 1, 1, 26'h0);
    dev_busy = 16'h0400;
    @(posedge clk); #1;
    chk("R9 one edge", {31'h0, rdy_bsy}, 32'h1);
    @(posedge clk); #1;
    chk("R9 busy", {31'h0, rdy_bsy}, 32'h0);
    @(negedge clk); dev_busy = 16'h8001;
    @(negedge clk); dev_busy = 16'h0;
    @(posedge clk); #1;
    chk("R9 still busy", {31'h0, rdy_bsy}, 32'h0);
    @(posedge clk); #1;
    chk("R9 ready", {31'h0, rdy_bsy}, 32'h1);
  endtask

  initial begin
    #100000;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_idle();
    t_word();
    t_even_only();
    t_odd_only();
    t_rw_both();
    t_attr();
    t_wp();
    t_busy();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule